// File: doc/BRIEF.md
# Serial EEPROM Write-Protocol Slave

This block is the target side of a small serial EEPROM that is reached over a four-wire SPI link. Its storage is an on-chip array of 512 bytes. A host enables writes with one frame. It then sends a write frame that carries a nine-bit address and one or more data bytes. The block gathers those bytes in an eight-byte page buffer. It stores them in the array only when chip select returns high on a whole-byte boundary. After that it stays busy for a programmable number of system clock cycles. During that time the host can only poll the status byte.

All serial inputs cross into the system clock domain through two-flop synchronisers. SCK edges are detected in that domain, so SCK must be several times slower than the system clock. A write-protect pin and a two-bit protection level are static inputs that gate every write. A second, combinational port reads the array directly so that its contents can be inspected.

Top module: `eeprom_write_slave`

## Requirements
- R1: After reset the status byte reads 0x00 with protection level 0, every array location reads 0xFF, and `so` is 0.
- R2: The link runs in SPI mode 0, MSB first. Opcode 0x05 returns the status byte on `so`: bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are `blkLevel`, and bits 7:4 are 0. The byte is sent again, freshly sampled, for every further byte while chip select stays low.
- R3: Opcode 0x06 sets the write-enable latch when not busy. The latch shows as status bit 1 in later frames.
- R4: A write frame is the opcode 0x02 with address bit 8 in opcode bit 3, then the low address byte, then data bytes. It is stored at chip-select rise when the latch is set and `wrProtN` is high.
- R5: Each data byte advances only the low 3 address bits, wrapping within the 8-byte page. When more than 8 bytes are sent, a later byte replaces an earlier one at the same location.
- R6: If chip select rises in the middle of a byte, or before the first data byte, the write is dropped. The array and the write-enable latch are left unchanged.
- R7: If `wrProtN` is low or the write-enable latch is clear at chip-select rise, the write is dropped and the array is unchanged.
- R8: `blkLevel` protects part of the array. 1 protects 0x180-0x1FF, 2 protects 0x100-0x1FF, and 3 protects the whole array. A write to a protected page is not stored.
- R9: A stored write makes the block busy for exactly `BUSY_CYCLES` clock cycles. Status bit 0 reads 1 during that time.
- R10: While busy, every opcode except 0x05 is ignored. A write sent during that time stores nothing, and 0x06 does not set the latch.
- R11: The write-enable latch clears by itself when the busy period ends.
- R12: After an opcode that is unknown or ignored, the rest of that frame is ignored until chip select falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial status data out, 0 when not sending |
| wrProtN | input | 1 | Write-protect pin; writes allowed only when high |
| blkLevel | input | 2 | Block protection level |
| inspAddr | input | ADDR_W (9) | Array inspection address |
| inspData | output | 8 | Array byte at `inspAddr` |

## Verification
Some rules hold on every cycle, and the bound checker checks those. A store fires only with the latch set, while idle, and outside the protected range. Every store opens a busy window of exactly `BUSY_CYCLES`. The latch never rises inside that window and is clear when it closes. Other behaviour only shows in the bench's frame sequences: the bit-level framing, page wrap and overwrite, aborted frames, the ignored commands, and the status bytes as seen on `so`. The bench checks these against a reference array that it keeps itself.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_WREN     = 8'h06;
  localparam logic [7:0] OP_RDSR     = 8'h05;
  localparam logic [7:0] OP_WRITE    = 8'h02;
  localparam logic [7:0] OP_HIADDR_M = 8'hF7;  // bit 3 carries the top address bit

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_STAT,
    ST_SKIP
  } frameState_t;

  typedef struct packed {
    logic startFrame;
    logic capHigh;
    logic capLow;
    logic pushData;
    logic commit;
    logic loadStat;
    logic soEn;
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_wr_sync.sv
module eeprom_wr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= RESET_VAL;
        else       chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/eeprom_wr_datapath.sv
module eeprom_wr_datapath
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int DEPTH      = 1 << ADDR_W,
  localparam int PAGE_LEN   = 1 << PAGE_W,
  localparam int PG_W       = ADDR_W - PAGE_W,
  localparam int HI_W       = ADDR_W - BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sck,
  input  logic                 si,
  input  dpStrobe_t            ctl,
  input  logic [BYTE_W-1:0]    statusByte,
  input  logic [ADDR_W-1:0]    inspAddr,
  output logic [BYTE_W-1:0]    inspData,
  output logic                 so,
  output logic                 csLow,
  output logic                 byteDone,
  output logic                 bitZero,
  output logic [BYTE_W-1:0]    rxByte,
  output logic [PG_W-1:0]      pageAddr
);

  // input synchronisers
  logic csS, sckS, siS, sckPrev;

  eeprom_wr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncCs (
    .clk(clk), .rstN(rstN), .d(csN), .q(csS));
  eeprom_wr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncSck (
    .clk(clk), .rstN(rstN), .d(sck), .q(sckS));
  eeprom_wr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncSi (
    .clk(clk), .rstN(rstN), .d(si), .q(siS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;

  logic sckRise, sckFall;
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign csLow   = ~csS;

  // bit receiver
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (ctl.startFrame) begin
      bitCnt  <= '0;
    end else if (sckRise && csLow) begin
      rxShift <= {rxShift[BYTE_W-2:0], siS};
      bitCnt  <= bitCnt + 3'd1;
    end

  assign rxByte   = {rxShift[BYTE_W-2:0], siS};
  assign byteDone = sckRise & csLow & (bitCnt == 3'd7);
  assign bitZero  = (bitCnt == 3'd0);

  // address register and page buffer
  logic [ADDR_W-1:0] addrReg;
  logic [BYTE_W-1:0] pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pageVld;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      addrReg <= '0;
      pageVld <= '0;
      for (int i = 0; i < PAGE_LEN; i++) pageBuf[i] <= '0;
    end else begin
      if (ctl.startFrame) pageVld <= '0;
      if (ctl.capHigh) addrReg[ADDR_W-1:BYTE_W] <= rxByte[3 +: HI_W];
      if (ctl.capLow)  addrReg[BYTE_W-1:0]      <= rxByte;
      if (ctl.pushData) begin
        pageBuf[addrReg[PAGE_W-1:0]] <= rxByte;
        pageVld[addrReg[PAGE_W-1:0]] <= 1'b1;
        addrReg[PAGE_W-1:0]          <= addrReg[PAGE_W-1:0] + PAGE_W'(1);
      end
    end

  assign pageAddr = addrReg[ADDR_W-1:PAGE_W];

  // storage array
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= 8'hFF;
    end else if (ctl.commit) begin
      for (int i = 0; i < PAGE_LEN; i++)
        if (pageVld[i]) mem[{pageAddr, PAGE_W'(i)}] <= pageBuf[i];
    end

  assign inspData = mem[inspAddr];

  // status transmitter
  logic [BYTE_W-1:0] soReg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)
      soReg <= '0;
    else if (ctl.loadStat)
      soReg <= statusByte;
    else if (ctl.soEn && sckFall && !bitZero)
      soReg <= {soReg[BYTE_W-2:0], 1'b0};

  assign so = ctl.soEn & soReg[BYTE_W-1];

endmodule

// File: rtl/eeprom_wr_control.sv
module eeprom_wr_control
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2,
  localparam int PG_W       = ADDR_W - PAGE_W,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csLow,
  input  logic              byteDone,
  input  logic              bitZero,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [PG_W-1:0]   pageAddr,
  input  logic              wrProtN,
  input  logic [1:0]        blkLevel,
  output dpStrobe_t         ctl,
  output logic              busy,
  output logic              wel,
  output logic [BYTE_W-1:0] statusByte
);

  logic wpOk;
  eeprom_wr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncWp (
    .clk(clk), .rstN(rstN), .d(wrProtN), .q(wpOk));

  frameState_t state, stateNxt;
  logic        gotData;
  logic        welSet;
  logic        inProt;
  logic [CNT_W-1:0] busyCnt;

  always_comb begin
    unique case (blkLevel)
      2'd0:    inProt = 1'b0;
      2'd1:    inProt = pageAddr[PG_W-1] & pageAddr[PG_W-2];
      2'd2:    inProt = pageAddr[PG_W-1];
      default: inProt = 1'b1;
    endcase
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    welSet   = 1'b0;
    unique case (state)
      ST_IDLE:
        if (csLow) begin
          ctl.startFrame = 1'b1;
          stateNxt       = ST_CMD;
        end
      ST_CMD:
        if (!csLow) stateNxt = ST_IDLE;
        else if (byteDone) begin
          if (rxByte == OP_RDSR) begin
            ctl.loadStat = 1'b1;
            stateNxt     = ST_STAT;
          end else if (busy) begin
            stateNxt = ST_SKIP;
          end else if (rxByte == OP_WREN) begin
            welSet   = 1'b1;
            stateNxt = ST_SKIP;
          end else if ((rxByte & OP_HIADDR_M) == OP_WRITE) begin
            ctl.capHigh = 1'b1;
            stateNxt    = ST_ADDR;
          end else begin
            stateNxt = ST_SKIP;
          end
        end
      ST_ADDR:
        if (!csLow) stateNxt = ST_IDLE;
        else if (byteDone) begin
          ctl.capLow = 1'b1;
          stateNxt   = ST_DATA;
        end
      ST_DATA:
        if (!csLow) begin
          ctl.commit = bitZero & gotData & wel & wpOk & ~inProt;
          stateNxt   = ST_IDLE;
        end else if (byteDone) begin
          ctl.pushData = 1'b1;
        end
      ST_STAT: begin
        ctl.soEn = 1'b1;
        if (!csLow) stateNxt = ST_IDLE;
        else if (byteDone) ctl.loadStat = 1'b1;
      end
      default:
        if (!csLow) stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state   <= ST_IDLE;
      gotData <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.startFrame)    gotData <= 1'b0;
      else if (ctl.pushData) gotData <= 1'b1;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      busyCnt <= '0;
      wel     <= 1'b0;
    end else begin
      if (ctl.commit)          busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busyCnt != '0)  busyCnt <= busyCnt - CNT_W'(1);

      if (busyCnt == CNT_W'(1)) wel <= 1'b0;
      else if (welSet)          wel <= 1'b1;
    end

  assign busy       = (busyCnt != '0);
  assign statusByte = {4'b0000, blkLevel, wel, busy};

endmodule

// File: rtl/eeprom_write_slave.sv
module eeprom_write_slave
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2,
  localparam int PG_W       = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  input  logic              wrProtN,
  input  logic [1:0]        blkLevel,
  input  logic [ADDR_W-1:0] inspAddr,
  output logic [7:0]        inspData
);

  dpStrobe_t          dpStb;
  logic               csLow, byteDone, bitZero, busy, wel, commitStb;
  logic [BYTE_W-1:0]  rxByte, statusByte;
  logic [PG_W-1:0]    pageAddr;

  assign commitStb = dpStb.commit;

  eeprom_wr_control #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .BUSY_CYCLES(BUSY_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csLow(csLow), .byteDone(byteDone),
    .bitZero(bitZero), .rxByte(rxByte), .pageAddr(pageAddr),
    .wrProtN(wrProtN), .blkLevel(blkLevel), .ctl(dpStb),
    .busy(busy), .wel(wel), .statusByte(statusByte)
  );

  eeprom_wr_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .ctl(dpStb), .statusByte(statusByte), .inspAddr(inspAddr),
    .inspData(inspData), .so(so), .csLow(csLow), .byteDone(byteDone),
    .bitZero(bitZero), .rxByte(rxByte), .pageAddr(pageAddr)
  );

endmodule

// File: rtl/eeprom_wr_checker.sv
module eeprom_wr_checker #(
  parameter int BUSY_CYCLES = 2000,
  parameter int PG_W        = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            wel,
  input logic            commitStb,
  input logic [1:0]      blkLevel,
  input logic [PG_W-1:0] pageAddr
);

  logic guarded;
  always_comb begin
    case (blkLevel)
      2'd0:    guarded = 1'b0;
      2'd1:    guarded = (pageAddr[PG_W-1 -: 2] == 2'b11);
      2'd2:    guarded = pageAddr[PG_W-1];
      default: guarded = 1'b1;
    endcase
  end

  int runLen;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)     runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;

  // R4, R7: a store needs the enable latch
  p_commit_needs_wel_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> wel);

  // R8: no store into a protected page
  p_commit_unprotected_r8: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !guarded);

  // R9: a store opens the busy window
  p_busy_follows_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> busy);

  // R9: busy window has the configured length
  p_busy_length_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == BUSY_CYCLES));

  // R10: no store while busy
  p_no_commit_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !commitStb);

  // R10: latch cannot be set inside the busy window
  p_wel_hold_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !$rose(wel));

  // R11: latch is clear when the window closes
  p_wel_cleared_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

endmodule

bind eeprom_write_slave eeprom_wr_checker #(
  .BUSY_CYCLES(BUSY_CYCLES), .PG_W(PG_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .wel(wel),
  .commitStb(commitStb), .blkLevel(blkLevel), .pageAddr(pageAddr)
);

// File: tb/tb_eeprom_write_slave.sv
`timescale 1ns/1ps
module tb_eeprom_write_slave;

  localparam int BUSY = 1500;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, sck = 1'b0, si = 1'b0, wrProtN = 1'b1;
  logic [1:0] blkLevel = 2'd0;
  logic [8:0] inspAddr = '0;
  logic       so;
  logic [7:0] inspData;

  always #2.5 clk = ~clk;

  eeprom_write_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .so(so),
    .wrProtN(wrProtN), .blkLevel(blkLevel), .inspAddr(inspAddr),
    .inspData(inspData)
  );

  int total = 0, fails = 0;
  logic [7:0] model [512];

  typedef struct packed {
    logic [8:0] addr;
    logic [7:0] data;
    logic [1:0] lvl;
    logic       allowed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{9'h005, 8'hA5, 2'd0, 1'b1},
    '{9'h1F0, 8'h3C, 2'd0, 1'b1},
    '{9'h1F8, 8'h11, 2'd1, 1'b0},
    '{9'h17F, 8'h22, 2'd1, 1'b1},
    '{9'h180, 8'h33, 2'd1, 1'b0},
    '{9'h100, 8'h44, 2'd2, 1'b0},
    '{9'h0FF, 8'h55, 2'd2, 1'b1},
    '{9'h000, 8'h66, 2'd3, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nb; b--) begin
      si = tx[b];
      tick(HALF);
      rx[b] = so;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic frameBegin;
    csN = 1'b0;
    tick(HALF);
  endtask

  task automatic frameEnd;
    tick(HALF);
    csN = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic cmdFrame(input logic [7:0] op);
    logic [7:0] d;
    frameBegin; xfer(op, d); frameEnd;
  endtask

  task automatic readStatus(output logic [7:0] st);
    logic [7:0] d;
    frameBegin; xfer(8'h05, d); xfer(8'h00, st); frameEnd;
  endtask

  task automatic writeFrame(input logic [8:0] a, input logic [7:0] base, input int n);
    logic [7:0] d;
    frameBegin;
    xfer({4'b0000, a[8], 3'b010}, d);
    xfer(a[7:0], d);
    for (int k = 0; k < n; k++) xfer(base + 8'(k), d);
    frameEnd;
  endtask

  task automatic peek(input logic [8:0] a, output logic [7:0] v);
    inspAddr = a;
    #1;
    v = inspData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun;
  end

  initial begin
    logic [7:0] st, st2, v, d;
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    tick(4);
    rstN = 1'b1;
    tick(4);

    // R1 reset state
    check("R1 so idle", 16'(so), 16'h0);
    peek(9'h000, v); check("R1 mem[000]", 16'(v), 16'hFF);
    peek(9'h1FF, v); check("R1 mem[1FF]", 16'(v), 16'hFF);
    readStatus(st);  check("R1 status", 16'(st), 16'h00);

    // R2 level bits reported
    blkLevel = 2'd2;
    readStatus(st);  check("R2 status level", 16'(st), 16'h08);
    blkLevel = 2'd0;

    // R12 unknown opcode, trailing WREN ignored
    frameBegin; xfer(8'hFF, d); xfer(8'h06, d); frameEnd;
    readStatus(st);  check("R12 wel after skip", 16'(st), 16'h00);

    // R3 enable latch
    cmdFrame(8'h06);
    readStatus(st);  check("R3 wel set", 16'(st), 16'h02);

    // R6 partial byte and no-data frames
    frameBegin; xfer(8'h02, d); xfer(8'h60, d); xfer(8'hAB, d); xferBits(8'hCD, 4, d); frameEnd;
    tick(20);
    peek(9'h060, v); check("R6 partial byte no store", 16'(v), 16'hFF);
    readStatus(st);  check("R6 wel kept", 16'(st), 16'h02);
    writeFrame(9'h061, 8'h00, 0);
    peek(9'h061, v); check("R6 no data no store", 16'(v), 16'hFF);
    readStatus(st);  check("R6 wel kept, idle", 16'(st), 16'h02);

    // R7 write-protect pin low
    wrProtN = 1'b0;
    tick(4);
    writeFrame(9'h070, 8'h70, 1);
    peek(9'h070, v); check("R7 wp low no store", 16'(v), 16'hFF);
    readStatus(st);  check("R7 not busy", 16'(st), 16'h02);
    wrProtN = 1'b1;
    tick(4);

    // R4 R5 page write with wrap, R9 busy, R10 ignored during busy
    writeFrame(9'h1A6, 8'hC1, 3);
    model[9'h1A6] = 8'hC1; model[9'h1A7] = 8'hC2; model[9'h1A0] = 8'hC3;
    readStatus(st);  check("R9 busy status", 16'(st), 16'h03);
    cmdFrame(8'h06);
    writeFrame(9'h010, 8'h5A, 1);
    tick(BUSY);
    peek(9'h1A6, v); check("R4 mem[1A6]", 16'(v), 16'(model[9'h1A6]));
    peek(9'h1A7, v); check("R5 mem[1A7]", 16'(v), 16'(model[9'h1A7]));
    peek(9'h1A0, v); check("R5 wrap mem[1A0]", 16'(v), 16'(model[9'h1A0]));
    peek(9'h1A1, v); check("R5 mem[1A1] untouched", 16'(v), 16'hFF);
    peek(9'h010, v); check("R10 write while busy", 16'(v), 16'hFF);
    readStatus(st);  check("R11 wel cleared, idle", 16'(st), 16'h00);

    // R7 latch clear
    writeFrame(9'h072, 8'h72, 1);
    peek(9'h072, v); check("R7 no wel no store", 16'(v), 16'hFF);

    // R5 overflow past 8 bytes, R2 repeated status bytes
    cmdFrame(8'h06);
    writeFrame(9'h040, 8'h90, 10);
    for (int k = 0; k < 10; k++) model[{6'h08, 3'(k)}] = 8'h90 + 8'(k);
    frameBegin; xfer(8'h05, d); xfer(8'h00, st); xfer(8'h00, st2); frameEnd;
    check("R2 status byte 1", 16'(st), 16'h03);
    check("R2 status byte 2", 16'(st2), 16'h03);
    tick(BUSY);
    peek(9'h040, v); check("R5 overwrite mem[040]", 16'(v), 16'h98);
    peek(9'h041, v); check("R5 overwrite mem[041]", 16'(v), 16'h99);
    peek(9'h042, v); check("R5 mem[042]", 16'(v), 16'h92);
    peek(9'h047, v); check("R5 mem[047]", 16'(v), 16'h97);

    // R8 protection table
    foreach (VECS[i]) begin
      blkLevel = VECS[i].lvl;
      cmdFrame(8'h06);
      writeFrame(VECS[i].addr, VECS[i].data, 1);
      tick(BUSY + 20);
      if (VECS[i].allowed) model[VECS[i].addr] = VECS[i].data;
      peek(VECS[i].addr, v);
      check($sformatf("R8 vec %0d", i), 16'(v), 16'(model[VECS[i].addr]));
    end

    finishRun;
  end

endmodule